// File: doc/BRIEF.md
# Serial Programming Loader for a Dual-Modulus Frequency Synthesizer

This block receives configuration words for a fractional-free PLL synthesizer over a three-wire serial port: a serial clock, a serial data line and a load strobe. All three wires are brought into the system clock domain through a synchronizer. Each rising edge of the serial clock moves one data bit into a 19-bit shift register, most significant bit first. The register keeps shifting whether or not the load strobe is asserted.

While the load strobe is high, the word in the shift register is copied into one of two holding registers. The destination is chosen by the last bit shifted in, which sits in bit 0. A one in bit 0 selects the reference register. That register holds a 14-bit reference ratio and three single-bit settings: prescaler modulus select, power enable and monitor-pin select. A zero in bit 0 selects the divider register, which holds a 7-bit swallow count and an 11-bit main count. A reference word whose ratio is below the legal floor of 6 is refused and raises a sticky error flag. The counters that use these fields are not part of this block.

Top module: `synth_prog_loader`

## Requirements
- R1: After reset the outputs are ref_ratio=6, pre_sel=0, pwr_on=0 (power save), mon_sel=0, swallow=0, main_div=5 and cfg_err=0.
- R2: Each rising edge of ser_clk shifts ser_data into bit 0 of the shift register, and the older bits move up by one. Only the last 19 bits shifted in are kept, and the oldest bit is lost.
- R3: While ser_load is high and bit 0 is 1, the reference register loads ref_ratio from bits 14:1, pre_sel from bit 15, pwr_on from bit 16 and mon_sel from bit 17. Bit 18 is ignored. An 18-bit reference word is therefore sent as {mon_sel, pwr_on, pre_sel, ratio[13:0], 1}, MSB first.
- R4: While ser_load is high and bit 0 is 0, the divider register loads swallow from bits 7:1 and main_div from bits 18:8. A 19-bit divider word is therefore sent as {main[10:0], swallow[6:0], 0}, MSB first.
- R5: While ser_load is low, every output holds its value. Shifting still goes on, so a later load strobe with no new bits shifted latches the word that was shifted in earlier.
- R6: A reference word whose ratio is below 6 changes none of the reference outputs and sets cfg_err.
- R7: The ratio values 6 and 16383 are accepted and appear unchanged on ref_ratio.
- R8: Loading one destination register leaves every output of the other register unchanged.
- R9: Once set, cfg_err stays high until reset, including across later valid loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock; its rising edges shift data in |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; the selected register updates while it is high |
| ref_ratio | output | 14 | Latched reference divide ratio |
| pre_sel | output | 1 | Latched prescaler modulus select |
| pwr_on | output | 1 | Latched power enable (0 = power save) |
| mon_sel | output | 1 | Latched monitor-pin select |
| swallow | output | 7 | Latched swallow count |
| main_div | output | 11 | Latched main count |
| cfg_err | output | 1 | Sticky flag: a reference ratio below the floor was refused |

## Verification
The bench builds the block with a three-stage synchronizer in place of the default two, so the deeper input pipeline and its extra latency are exercised. It keeps the default ratio floor of 6 and the full field widths. This makes both ratio ends reachable: the rejected values 0 to 5, the boundary values 6 and 16383, and an 11-bit main count up to 2047. Randomly mixed reference and divider words are interleaved with directed cases:
- over-length bursts whose extra leading bits must be lost;
- words shifted in with no load strobe;
- a load strobe with no new shifting.

// File: rtl/prog_loader_pkg.sv
package prog_loader_pkg;

    localparam int REF_W   = 14;
    localparam int SWAL_W  = 7;
    localparam int MAIN_W  = 11;
    localparam int REF_WORD_W = 1 + REF_W + 3;
    localparam int DIV_WORD_W = 1 + SWAL_W + MAIN_W;
    localparam int SR_W    = (REF_WORD_W > DIV_WORD_W) ? REF_WORD_W : DIV_WORD_W;

    localparam int REF_LSB  = 1;
    localparam int SEL_BIT  = REF_LSB + REF_W;
    localparam int PWR_BIT  = SEL_BIT + 1;
    localparam int MON_BIT  = PWR_BIT + 1;
    localparam int SWAL_LSB = 1;
    localparam int MAIN_LSB = SWAL_LSB + SWAL_W;

    typedef struct packed {
        logic [REF_W-1:0] ratio;
        logic             pre_sel;
        logic             pwr_on;
        logic             mon_sel;
    } ref_cfg_t;

    typedef struct packed {
        logic [SWAL_W-1:0] swallow;
        logic [MAIN_W-1:0] main_div;
    } div_cfg_t;

endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/prog_shifter.sv
module prog_shifter
    import prog_loader_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_clk,
    input  logic            bit_val,
    output logic [SR_W-1:0] word
);

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic            clk_prev;
    } shift_state_t;

    shift_state_t st_d;
    shift_state_t st_q;
    logic         rise;

    always_comb begin
        st_d          = st_q;
        rise          = bit_clk & ~st_q.clk_prev;
        st_d.clk_prev = bit_clk;
        if (rise) begin
            st_d.sr = {st_q.sr[SR_W-2:0], bit_val};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.sr;

endmodule

// File: rtl/prog_latches.sv
module prog_latches
    import prog_loader_pkg::*;
#(
    parameter int REF_MIN      = 6,
    parameter int MAIN_DEFAULT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SR_W-1:0] word,
    output ref_cfg_t        ref_cfg,
    output div_cfg_t        div_cfg,
    output logic            err
);

    typedef struct packed {
        ref_cfg_t ref_r;
        div_cfg_t div_r;
        logic     err;
    } latch_state_t;

    localparam ref_cfg_t REF_RST = '{ratio: REF_W'(REF_MIN), pre_sel: 1'b0,
                                     pwr_on: 1'b0, mon_sel: 1'b0};
    localparam div_cfg_t DIV_RST = '{swallow: '0, main_div: MAIN_W'(MAIN_DEFAULT)};

    latch_state_t      st_d;
    latch_state_t      st_q;
    logic [REF_W-1:0]  new_ratio;
    logic              ratio_ok;

    always_comb begin
        st_d      = st_q;
        new_ratio = word[REF_LSB +: REF_W];
        ratio_ok  = (32'(new_ratio) >= REF_MIN);
        if (load) begin
            if (word[0]) begin
                if (ratio_ok) begin
                    st_d.ref_r.ratio   = new_ratio;
                    st_d.ref_r.pre_sel = word[SEL_BIT];
                    st_d.ref_r.pwr_on  = word[PWR_BIT];
                    st_d.ref_r.mon_sel = word[MON_BIT];
                end else begin
                    st_d.err = 1'b1;
                end
            end else begin
                st_d.div_r.swallow  = word[SWAL_LSB +: SWAL_W];
                st_d.div_r.main_div = word[MAIN_LSB +: MAIN_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ref_r: REF_RST, div_r: DIV_RST, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_cfg = st_q.ref_r;
    assign div_cfg = st_q.div_r;
    assign err     = st_q.err;

endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
    import prog_loader_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int REF_MIN      = 6,
    parameter int MAIN_DEFAULT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_load,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              pre_sel,
    output logic              pwr_on,
    output logic              mon_sel,
    output logic [SWAL_W-1:0] swallow,
    output logic [MAIN_W-1:0] main_div,
    output logic              cfg_err
);

    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_sync;
    logic [SR_W-1:0]  word;
    ref_cfg_t         ref_cfg;
    div_cfg_t         div_cfg;

    prog_sync #(.STAGES(SYNC_STAGES), .WIDTH(PIN_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_load, ser_data, ser_clk}),
        .sync_out (pins_sync)
    );

    prog_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_clk (pins_sync[0]),
        .bit_val (pins_sync[1]),
        .word    (word)
    );

    prog_latches #(.REF_MIN(REF_MIN), .MAIN_DEFAULT(MAIN_DEFAULT)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pins_sync[2]),
        .word    (word),
        .ref_cfg (ref_cfg),
        .div_cfg (div_cfg),
        .err     (cfg_err)
    );

    assign ref_ratio = ref_cfg.ratio;
    assign pre_sel   = ref_cfg.pre_sel;
    assign pwr_on    = ref_cfg.pwr_on;
    assign mon_sel   = ref_cfg.mon_sel;
    assign swallow   = div_cfg.swallow;
    assign main_div  = div_cfg.main_div;

endmodule

// File: rtl/prog_loader_checker.sv
module prog_loader_checker
    import prog_loader_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REF_MIN     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_load,
    input logic [REF_W-1:0]  ref_ratio,
    input logic              pre_sel,
    input logic              pwr_on,
    input logic              mon_sel,
    input logic [SWAL_W-1:0] swallow,
    input logic [MAIN_W-1:0] main_div,
    input logic              cfg_err
);

    localparam int QUIET_MAX = SYNC_STAGES + 3;

    int  quiet_cnt;
    logic quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= 0;
        end else if (ser_load) begin
            quiet_cnt <= 0;
        end else if (quiet_cnt < QUIET_MAX) begin
            quiet_cnt <= quiet_cnt + 1;
        end
    end

    assign quiet = (quiet_cnt > SYNC_STAGES + 1);

    // R5: no strobe in the pipeline, no output may move
    a_r5_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> ($stable(ref_ratio) && $stable(pre_sel) && $stable(pwr_on) &&
                   $stable(mon_sel) && $stable(swallow) && $stable(main_div)));

    // R6: the latched ratio never sits below the floor
    a_r6_ratio_floor: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ref_ratio) >= REF_MIN);

    // R9: the error flag never falls outside reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err) |-> cfg_err);

    // R6: the error flag only rises in answer to a load strobe
    a_r6_err_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !quiet);

    // R8: a reference change and a divider change never share a cycle
    a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(ref_ratio) && $stable(pre_sel) && $stable(pwr_on) && $stable(mon_sel))
        |-> ($stable(swallow) && $stable(main_div)));

endmodule

bind synth_prog_loader prog_loader_checker #(
    .SYNC_STAGES (SYNC_STAGES),
    .REF_MIN     (REF_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_load  (ser_load),
    .ref_ratio (ref_ratio),
    .pre_sel   (pre_sel),
    .pwr_on    (pwr_on),
    .mon_sel   (mon_sel),
    .swallow   (swallow),
    .main_div  (main_div),
    .cfg_err   (cfg_err)
);

// File: tb/synth_prog_loader_bench.sv
module synth_prog_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_load = 1'b0;
    logic [13:0] ref_ratio;
    logic        pre_sel, pwr_on, mon_sel;
    logic [6:0]  swallow;
    logic [10:0] main_div;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [13:0] e_ratio;
    logic        e_sel, e_pwr, e_mon, e_err;
    logic [6:0]  e_swal;
    logic [10:0] e_main;

    always #4 clk = ~clk;

    synth_prog_loader #(.SYNC_STAGES(3)) u_synth_prog_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .ref_ratio(ref_ratio), .pre_sel(pre_sel),
        .pwr_on(pwr_on), .mon_sel(mon_sel), .swallow(swallow),
        .main_div(main_div), .cfg_err(cfg_err)
    );

    task automatic chk(string tag, string fld, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        @(negedge clk);
        chk(tag, "ref_ratio", int'(ref_ratio), int'(e_ratio));
        chk(tag, "pre_sel",   int'(pre_sel),   int'(e_sel));
        chk(tag, "pwr_on",    int'(pwr_on),    int'(e_pwr));
        chk(tag, "mon_sel",   int'(mon_sel),   int'(e_mon));
        chk(tag, "swallow",   int'(swallow),   int'(e_swal));
        chk(tag, "main_div",  int'(main_div),  int'(e_main));
        chk(tag, "cfg_err",   int'(cfg_err),   int'(e_err));
    endtask

    task automatic shift_bits(int nbits, logic [31:0] val);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_data = val[i];
            ser_clk  = 1'b0;
            repeat (4) @(negedge clk);
            ser_clk  = 1'b1;
            repeat (4) @(negedge clk);
        end
        @(negedge clk);
        ser_clk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_load();
        @(negedge clk);
        ser_load = 1'b1;
        repeat (4) @(negedge clk);
        ser_load = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [17:0] ref_word(logic [13:0] r, logic s, logic p, logic m);
        return {m, p, s, r, 1'b1};
    endfunction

    function automatic logic [18:0] div_word(logic [10:0] n, logic [6:0] a);
        return {n, a, 1'b0};
    endfunction

    task automatic model_ref(logic [13:0] r, logic s, logic p, logic m);
        if (r < 14'd6) begin
            e_err = 1'b1;
        end else begin
            e_ratio = r; e_sel = s; e_pwr = p; e_mon = m;
        end
    endtask

    task automatic send_ref(logic [13:0] r, logic s, logic p, logic m);
        shift_bits(18, 32'(ref_word(r, s, p, m)));
        pulse_load();
        model_ref(r, s, p, m);
    endtask

    task automatic send_div(logic [10:0] n, logic [6:0] a);
        shift_bits(19, 32'(div_word(n, a)));
        pulse_load();
        e_main = n; e_swal = a;
    endtask

    initial begin
        void'($urandom(32'h5eed_0417));
        e_ratio = 14'd6; e_sel = 0; e_pwr = 0; e_mon = 0;
        e_swal = 7'd0; e_main = 11'd5; e_err = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1 reset");

        // R3 reference word, R8 divider untouched
        send_ref(14'd1234, 1'b1, 1'b1, 1'b0);
        check_all("R3 R8 ref load");
        // R4 divider word, R8 reference untouched
        send_div(11'd2047, 7'd127);
        check_all("R4 R8 div load");
        // R7 boundary ratios
        send_ref(14'd6, 1'b0, 1'b1, 1'b1);
        check_all("R7 ratio 6");
        send_ref(14'd16383, 1'b1, 1'b0, 1'b1);
        check_all("R7 ratio 16383");
        // R6 ratio below floor refused
        send_ref(14'd5, 1'b0, 1'b1, 1'b0);
        check_all("R6 ratio 5");
        send_ref(14'd0, 1'b1, 1'b1, 1'b1);
        check_all("R6 ratio 0");
        // R9 sticky across valid loads
        send_ref(14'd300, 1'b0, 1'b1, 1'b0);
        check_all("R9 sticky after ref");
        send_div(11'd5, 7'd0);
        check_all("R9 sticky after div");
        // R5 shifting without strobe changes nothing
        shift_bits(19, 32'(div_word(11'd777, 7'd33)));
        check_all("R5 no strobe");
        pulse_load();
        e_main = 11'd777; e_swal = 7'd33;
        check_all("R5 late strobe");
        // R2 over-length burst: oldest bits lost
        shift_bits(6, 32'h2a);
        shift_bits(19, 32'(div_word(11'd1000, 7'd90)));
        pulse_load();
        e_main = 11'd1000; e_swal = 7'd90;
        check_all("R2 overflow");
        // R2 reference word over leftover bit 18 of a previous word
        shift_bits(19, 32'h7ffff);
        send_ref(14'd4097, 1'b0, 1'b0, 1'b1);
        check_all("R2 R3 leftover bit18");

        for (int it = 0; it < 40; it++) begin
            if ($urandom_range(1, 0) == 1) begin
                logic [13:0] r;
                r = ($urandom_range(4, 0) == 0) ? 14'($urandom_range(7, 0))
                                                : 14'($urandom);
                send_ref(r, 1'($urandom), 1'($urandom), 1'($urandom));
                check_all("R3 R6 R8 random ref");
            end else begin
                send_div(11'($urandom), 7'($urandom));
                check_all("R4 R8 random div");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule